// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three independent 16-bit down-counters behind a byte-wide port with four addresses. Addresses 0, 1 and 2 are the data ports of counters 0, 1 and 2. Address 3 is a write-only control port.

A control byte does one of two things. It can program a counter for two-byte access in one of four counting modes, or it can freeze the counter's current value into a two-byte hold register so that software can read it without tearing. Every counter advances on a single-cycle `tick_en` strobe. Counter 0 raises a one-clock interrupt pulse when it reaches terminal count. In rate-generator mode it keeps pulsing periodically; in every other mode it pulses only once.

The port has no handshake. It accepts one access (a write or a read, never both) in every cycle and never stalls, so there is no back-pressure. Read data is registered and appears one clock after the read strobe.

Top module: `pit_top`

## Requirements
- R1: After reset every counter has no programmed reload value and runs from the default divisor 11932. No hold bytes are pending, both write byte pointers point at the low byte, `rdata` is 8'h00 and `irq` is low.
- R2: A write to address 3 is a control byte with fields select = bits 7:6, access = bits 5:4 and mode = bits 3:0. The byte is ignored in any of these cases: select is 2'b11; access is 2'b01 or 2'b10; access is 2'b11 and mode is not one of 4'h0 (one-shot interrupt), 4'h4 (rate generator), 4'h6 (square wave) or 4'h8 (software strobe).
- R3: Data-port writes go low byte first, then high byte. Only the high-byte write loads the new reload value, and the counter then restarts from it.
- R4: The live count equals the reload value minus (ticks since load, modulo the reload value). It runs reload, reload-1, …, 1, then reload again, and changes only in cycles where `tick_en` is high.
- R5: A reload value of 0 or 1 counts as the default divisor 11932, which is (1193182 + 50) / 100.
- R6: A latch command (access 2'b00) captures the live count into the hold register only when no hold bytes are pending. The capture is read back low byte then high byte. A second latch before both bytes are read is ignored, and the counter's mode does not change.
- R7: A valid programming command (access 2'b11) stores the mode and discards any pending hold bytes. It does not reload the count.
- R8: A read with nothing pending snapshots the live count and returns its low byte. The next read returns the high byte of that same snapshot. After that, reads follow the live count again.
- R9: When counter 0 is armed by a load and passes terminal count (the tick that takes it from 1 back to the reload value), `irq` pulses high for one clock. In mode 4'h4 it stays armed and pulses every period. In any other mode it disarms after one pulse, and a programming command also disarms it. Counters 1 and 2 never drive `irq`.
- R10: `rdata` takes the selected byte on the clock after `rd_en` and holds it otherwise. A read of address 3 returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count strobe, one clock wide per input tick |
| wr_en | input | 1 | Write strobe for the port access |
| rd_en | input | 1 | Read strobe for the port access |
| addr | input | 2 | 0..2 counter data ports, 3 control port |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| irq | output | 1 | One-clock terminal-count pulse from counter 0 |

## Verification
Counting is exercised with free-running ticks at the default divisor, with small loaded reload values, and with a split write where ticks arrive between the low and the high byte. Together these separate "load on the high byte" from "load on either byte". Latch traffic is driven in three ways: repeated latches, latches broken off by a programming command, and latches followed by control bytes that must be rejected. A fresh low byte coming back where a held high byte is expected shows that a command was wrongly accepted or a hold was wrongly dropped. The interrupt path is run in one-shot mode, in rate-generator mode with a latch issued in mid-run, and with reload value 1. Counting the pulses over each run tells periodic behaviour from single-pulse behaviour and shows whether the fallback divisor is applied.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int NUM_CH = 3;

  localparam logic [1:0] CTRL_ADDR  = 2'd3;
  localparam logic [1:0] ACC_LATCH  = 2'b00;
  localparam logic [1:0] ACC_WORD   = 2'b11;
  localparam logic [3:0] MODE_RATE  = 4'h4;

  function automatic logic mode_ok(input logic [3:0] m);
    return (m == 4'h0) || (m == 4'h4) || (m == 4'h6) || (m == 4'h8);
  endfunction

  function automatic int round_div(input int num, input int den);
    return (num + den / 2) / den;
  endfunction
endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
  import pit_pkg::*;
(
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [NUM_CH-1:0] prog_vec,
  output logic [NUM_CH-1:0] latch_vec,
  output logic [NUM_CH-1:0] dwr_vec,
  output logic [3:0]        mode
);
  logic       is_ctrl;
  logic [1:0] sel;
  logic [1:0] acc;

  assign is_ctrl = wr_en && (addr == CTRL_ADDR);
  assign sel     = wdata[7:6];
  assign acc     = wdata[5:4];
  assign mode    = wdata[3:0];

  // select 2'b11 never matches a channel index, so read-back is dropped
  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign latch_vec[i] = is_ctrl && (sel == 2'(i)) && (acc == ACC_LATCH);
    assign prog_vec[i]  = is_ctrl && (sel == 2'(i)) && (acc == ACC_WORD) && mode_ok(mode);
    assign dwr_vec[i]   = wr_en && (addr == 2'(i));
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter logic [15:0] DEF_DIV = 16'd11932
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              prog_en,
  input  logic [3:0]        prog_mode,
  input  logic              latch_en,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              tc_pulse
);
  logic [CNT_W-1:0]  init_q, count_q, hold_q;
  logic [CNT_W-1:0]  eff_init, new_init, new_eff;
  logic [BYTE_W-1:0] lo_q;
  logic [3:0]        mode_q;
  logic [1:0]        pend_q;
  logic              wptr_q, armed_q, tc_q;
  logic              load, tc;

  assign eff_init = (init_q > CNT_W'(1)) ? init_q : DEF_DIV;
  assign new_init = {wdata, lo_q};
  assign new_eff  = (new_init > CNT_W'(1)) ? new_init : DEF_DIV;
  assign load     = wr_en && wptr_q;
  assign tc       = tick_en && !load && (count_q == CNT_W'(1));
  assign tc_pulse = tc_q;

  always_comb begin
    case (pend_q)
      2'd2:    rd_byte = hold_q[7:0];
      2'd1:    rd_byte = hold_q[15:8];
      default: rd_byte = count_q[7:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q  <= '0;
      count_q <= DEF_DIV;
      hold_q  <= '0;
      lo_q    <= '0;
      mode_q  <= '0;
      pend_q  <= '0;
      wptr_q  <= 1'b0;
      armed_q <= 1'b0;
      tc_q    <= 1'b0;
    end else begin
      tc_q <= tc && armed_q;

      if (wr_en) begin
        if (!wptr_q) lo_q <= wdata;
        wptr_q <= !wptr_q;
      end
      if (load) init_q <= new_init;

      if (load)
        count_q <= new_eff;
      else if (tick_en)
        count_q <= (count_q == CNT_W'(1)) ? eff_init : count_q - CNT_W'(1);

      if (load)
        armed_q <= 1'b1;
      else if (prog_en)
        armed_q <= 1'b0;
      else if (tc && armed_q && (mode_q != MODE_RATE))
        armed_q <= 1'b0;

      if (prog_en) mode_q <= prog_mode;

      if (prog_en) begin
        pend_q <= 2'd0;
      end else if (latch_en && (pend_q == 2'd0)) begin
        hold_q <= count_q;
        pend_q <= 2'd2;
      end else if (rd_en) begin
        case (pend_q)
          2'd0: begin
            hold_q <= count_q;
            pend_q <= 2'd1;
          end
          2'd2:    pend_q <= 2'd1;
          default: pend_q <= 2'd0;
        endcase
      end
    end
  end

  // R4
  count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q != '0);

  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load) |=> $stable(count_q));

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == 2'd2 && !rd_en && !prog_en) |=> (pend_q == 2'd2 && $stable(hold_q)));

  // R8
  read_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && pend_q == 2'd1 && !prog_en) |=> (pend_q == 2'd0));
endmodule

// File: rtl/pit_top.sv
module pit_top
  import pit_pkg::*;
#(
  parameter int               IN_HZ    = 1193182,
  parameter int               OUT_HZ   = 100,
  parameter logic [NUM_CH-1:0] IRQ_MASK = 3'b001
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq
);
  localparam logic [CNT_W-1:0] DEF_DIV = CNT_W'(round_div(IN_HZ, OUT_HZ));

  logic [NUM_CH-1:0] prog_vec, latch_vec, dwr_vec, tc_vec;
  logic [3:0]        mode;
  logic [BYTE_W-1:0] rd_mux [4];
  logic [BYTE_W-1:0] rdata_q;

  pit_ctrl_decode u_dec (
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .prog_vec  (prog_vec),
    .latch_vec (latch_vec),
    .dwr_vec   (dwr_vec),
    .mode      (mode)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pit_channel #(.DEF_DIV(DEF_DIV)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .prog_en   (prog_vec[i]),
      .prog_mode (mode),
      .latch_en  (latch_vec[i]),
      .wr_en     (dwr_vec[i]),
      .wdata     (wdata),
      .rd_en     (rd_en && (addr == 2'(i))),
      .rd_byte   (rd_mux[i]),
      .tc_pulse  (tc_vec[i])
    );
  end

  assign rd_mux[3] = '0;

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux[addr];
  end

  assign rdata = rdata_q;
  assign irq   = |(tc_vec & IRQ_MASK);

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/pit_top_test.sv
`timescale 1ns/1ps
module pit_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  wire  [7:0] rdata;
  wire        irq;

  always #10 clk = ~clk;

  pit_top uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  localparam int DEF = (1193182 + 50) / 100;

  int    checks = 0, errors = 0, pulses = 0, cyc = 0;
  string req = "R1";
  bit    done = 1'b0;

  // behavioural reference model
  int m_init [3], m_cnt [3], m_mode [3], m_lo [3], m_wptr [3];
  bit m_armed [3], m_loaded [3];
  int mq [3][$];
  int exp_rdata = 0;
  bit exp_irq = 1'b0, irq_nxt;
  int sel, acc, md, v;

  function automatic int eff(input int x);
    return (x > 1) ? x : DEF;
  endfunction

  task automatic chk(input string r, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_init[i] = 0; m_cnt[i] = DEF; m_mode[i] = 0; m_lo[i] = 0;
        m_wptr[i] = 0; m_armed[i] = 0; mq[i].delete();
      end
      exp_rdata = 0; exp_irq = 0;
    end else begin
      for (int i = 0; i < 3; i++) m_loaded[i] = 0;
      irq_nxt = 0;
      if (wr_en && addr == 2'd3) begin
        sel = wdata[7:6]; acc = wdata[5:4]; md = wdata[3:0];
        if (sel != 3) begin
          if (acc == 0) begin
            if (mq[sel].size() == 0) begin
              mq[sel].push_back(m_cnt[sel] % 256);
              mq[sel].push_back(m_cnt[sel] / 256);
            end
          end else if (acc == 3 && (md == 0 || md == 4 || md == 6 || md == 8)) begin
            m_mode[sel] = md; mq[sel].delete(); m_armed[sel] = 0;
          end
        end
      end else if (wr_en) begin
        sel = addr;
        if (m_wptr[sel] == 0) begin
          m_lo[sel] = wdata; m_wptr[sel] = 1;
        end else begin
          m_init[sel] = wdata * 256 + m_lo[sel]; m_wptr[sel] = 0;
          m_cnt[sel] = eff(m_init[sel]); m_armed[sel] = 1; m_loaded[sel] = 1;
        end
      end
      if (rd_en) begin
        if (addr == 2'd3) exp_rdata = 0;
        else begin
          sel = addr;
          if (mq[sel].size() == 0) begin
            mq[sel].push_back(m_cnt[sel] % 256);
            mq[sel].push_back(m_cnt[sel] / 256);
          end
          v = mq[sel].pop_front();
          exp_rdata = v;
        end
      end
      if (tick_en) begin
        for (int i = 0; i < 3; i++) begin
          if (!m_loaded[i]) begin
            if (m_cnt[i] == 1) begin
              m_cnt[i] = eff(m_init[i]);
              if (m_armed[i]) begin
                if (i == 0) irq_nxt = 1;
                if (m_mode[i] != 4) m_armed[i] = 0;
              end
            end else m_cnt[i] = m_cnt[i] - 1;
          end
        end
      end
      exp_irq = irq_nxt;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(req, irq, exp_irq, "irq vs model");
      chk(req, rdata, exp_rdata, "rdata vs model");
      if (irq) pulses++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input int exp, input string r);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    chk(r, rdata, exp, "direct read");
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", rdata, 0, "reset rdata");
    chk("R1", irq, 0, "reset irq");
    rst_n = 1'b1;
    // R1/R5: default divisor 11932 = 0x2E9C
    req = "R1";
    rd_chk(2'd0, 8'h9C, "R1");
    rd_chk(2'd0, 8'h2E, "R1");
    // R4: ten ticks -> 11922 = 0x2E92
    req = "R4";
    ticks(10);
    rd_chk(2'd1, 8'h92, "R4");
    rd_chk(2'd1, 8'h2E, "R4");
    // R3: low byte then ticks, load only on high byte
    req = "R3";
    bus_wr(2'd3, 8'h70);
    bus_wr(2'd1, 8'd16);
    ticks(2);
    bus_wr(2'd1, 8'd0);
    ticks(3);
    rd_chk(2'd1, 13, "R3");
    rd_chk(2'd1, 0, "R3");
    // R6: latch held across ticks, second latch ignored
    req = "R6";
    bus_wr(2'd3, 8'h40);
    ticks(5);
    rd_chk(2'd1, 13, "R6");
    bus_wr(2'd3, 8'h40);
    ticks(2);
    rd_chk(2'd1, 0, "R6");
    // R8: live snapshot after the hold is consumed, 13-7 = 6
    req = "R8";
    rd_chk(2'd1, 6, "R8");
    rd_chk(2'd1, 0, "R8");
    // R7: ch2 at 11932-22 = 11910 = 0x2E86
    req = "R7";
    bus_wr(2'd3, 8'h80);
    rd_chk(2'd2, 8'h86, "R7");
    bus_wr(2'd3, 8'hB4);
    rd_chk(2'd2, 8'h86, "R7");
    rd_chk(2'd2, 8'h2E, "R7");
    // R2: rejected control bytes leave the hold pending
    req = "R2";
    bus_wr(2'd3, 8'h80);
    ticks(3);
    rd_chk(2'd2, 8'h86, "R2");
    bus_wr(2'd3, 8'hF0);
    bus_wr(2'd3, 8'h90);
    bus_wr(2'd3, 8'hA0);
    bus_wr(2'd3, 8'hB2);
    rd_chk(2'd2, 8'h2E, "R2");
    rd_chk(2'd2, 8'h83, "R2");
    rd_chk(2'd2, 8'h2E, "R2");
    // R9: one-shot on counter 0, reload 5, 12 ticks -> one pulse
    req = "R9";
    bus_wr(2'd3, 8'h30);
    bus_wr(2'd0, 8'd5);
    bus_wr(2'd0, 8'd0);
    pulses = 0;
    ticks(12);
    @(negedge clk);
    chk("R9", pulses, 1, "one-shot pulse count");
    // R9: rate generator reload 4, 13 ticks -> three pulses, latch mid-run
    bus_wr(2'd3, 8'h34);
    bus_wr(2'd0, 8'd4);
    bus_wr(2'd0, 8'd0);
    pulses = 0;
    ticks(6);
    bus_wr(2'd3, 8'h00);
    rd_chk(2'd0, 2, "R9");
    rd_chk(2'd0, 0, "R9");
    ticks(7);
    @(negedge clk);
    chk("R9", pulses, 3, "rate pulse count");
    // R5: reload 1 falls back to 11932 ticks per period
    req = "R5";
    bus_wr(2'd0, 8'd1);
    bus_wr(2'd0, 8'd0);
    pulses = 0;
    ticks(DEF - 1);
    @(negedge clk);
    chk("R5", pulses, 0, "no pulse before default period");
    ticks(1);
    @(negedge clk);
    chk("R5", pulses, 1, "pulse at default period");
    bus_wr(2'd1, 8'd0);
    bus_wr(2'd1, 8'd0);
    rd_chk(2'd1, 8'h9C, "R5");
    rd_chk(2'd1, 8'h2E, "R5");
    // R10: control address reads as zero
    req = "R10";
    rd_chk(2'd3, 0, "R10");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule